// File: doc/BRIEF.md
# Fixed-Latency Shared Line Memory

This block is a small backing store that charges a fixed access latency on every transaction. Two requesters share it: a data side (requester 0) and a fetch side (requester 1). Each side raises a request with an operation, an address and write data. It keeps presenting that request until its own done flag rises.

The store is organised as lines of `LINE_WORDS` words of `WORD_W` bits. An access moves either one word or one whole line. The store serves one access at a time. The first requester to be accepted owns a lock until its access completes. While it holds the lock, the other side is stalled: it is not queued and its cycle count does not advance. The owner's wait counter survives across the cycles in which it keeps its request asserted. If the owner drops its request early, the access is abandoned.

Top module: `lockmem`

## Requirements
- R1: With latency `LAT` (at least 1), a request held from an idle store reports not-done for `LAT` cycles and reports done in cycle `LAT+1`.
- R2: Storage changes only at the clock edge that ends a completing write. `rd_word` and `rd_line` are zero in every cycle where neither done flag is high.
- R3: While one requester owns the lock, the other requester's done stays low and its request makes no progress.
- R4: A requester that waited behind another starts its access in the cycle after the owner completes, then needs `LAT` not-done cycles plus one completion cycle. If it began one cycle after the owner, it sees `2*LAT+1` cycles in total.
- R5: If both requesters arrive at an idle store in the same cycle, the data side (requester 0) takes the lock first. A fetch read of the same location then returns the freshly written value.
- R6: Operation encoding: 00 word read, 01 word write, 10 line read, 11 line write. For word operations, the address bits above the low two select the line. The low two bits select word i, which sits at bits [32*i+31:32*i] of `rd_line`/`wline`.
- R7: Line operations move all four words at once and ignore the low two address bits.
- R8: The lock is released on the completion cycle. Every new access, including back-to-back word reads at consecutive addresses, pays the full `LAT+1` cycles.
- R9: If the owner drops its request before completion, the access is abandoned with no write, and the lock is freed on the next edge.
- R10: Synchronous active-high reset clears all storage, the wait counter and the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| d_req | input | 1 | Data-side request held until done |
| d_op | input | 2 | Data-side operation code |
| d_addr | input | AW | Data-side word address |
| d_wword | input | WORD_W | Data-side write word |
| d_wline | input | LINE_WORDS*WORD_W | Data-side write line |
| f_req | input | 1 | Fetch-side request held until done |
| f_op | input | 2 | Fetch-side operation code |
| f_addr | input | AW | Fetch-side word address |
| f_wword | input | WORD_W | Fetch-side write word |
| f_wline | input | LINE_WORDS*WORD_W | Fetch-side write line |
| d_done | output | 1 | Data-side access completes this cycle |
| f_done | output | 1 | Fetch-side access completes this cycle |
| rd_word | output | WORD_W | Read word, valid on the completing cycle |
| rd_line | output | LINE_WORDS*WORD_W | Read line, valid on the completing cycle |

## Verification
The bench counts cycles from request to done. A wait counter that is wrong shows up at once as a cycle count that is not `LAT+1` or `2*LAT+1`. A lock owner that is wrong shows up as the losing side finishing first, or both sides finishing together. A write that lands early, or that survives an abort, does not show in the cycle counts. It appears only on the next read of that location, at most `LAT+1` cycles later. That is why the sweeps read back every word and every line.

// File: rtl/lockmem_pkg.sv
package lockmem_pkg;
    typedef enum logic [1:0] {
        OP_RD_WORD = 2'b00,
        OP_WR_WORD = 2'b01,
        OP_RD_LINE = 2'b10,
        OP_WR_LINE = 2'b11
    } mem_op_e;
endpackage

// File: rtl/lockmem_lock.sv
module lockmem_lock #(
    parameter int LAT = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] req,
    output logic [1:0] done,
    output logic       owner
);
    localparam int CW = $clog2(LAT + 1);

    typedef struct packed {
        logic          busy;
        logic          owner;
        logic [CW-1:0] cnt;
    } lock_t;

    lock_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        done = '0;
        if (!st_q.busy) begin
            if (|req) begin
                st_d.busy  = 1'b1;
                st_d.owner = ~req[0];
                st_d.cnt   = CW'(1);
            end
        end else if (!req[st_q.owner]) begin
            st_d.busy = 1'b0;
            st_d.cnt  = '0;
        end else if (st_q.cnt == CW'(LAT)) begin
            done[st_q.owner] = 1'b1;
            st_d.busy        = 1'b0;
            st_d.cnt         = '0;
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign owner = st_q.owner;

    p_done_after_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (|done) |-> ($past(st_q.busy) && $past(req[st_q.owner])));
    p_owner_kept_r3: assert property (@(posedge clk) disable iff (rst)
        (st_q.busy && req[st_q.owner] && !(|done)) |=> (st_q.busy && $stable(st_q.owner)));
    p_prio_r5: assert property (@(posedge clk) disable iff (rst)
        (!st_q.busy && req[0]) |=> (st_q.busy && !st_q.owner));
    p_release_r8: assert property (@(posedge clk) disable iff (rst)
        (|done) |=> !st_q.busy);
    p_abort_r9: assert property (@(posedge clk) disable iff (rst)
        (st_q.busy && !req[st_q.owner]) |=> !st_q.busy);
endmodule

// File: rtl/lockmem_array.sv
module lockmem_array #(
    parameter int NLINES     = 16,
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 4
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 wr_word_en,
    input  logic                                 wr_line_en,
    input  logic                                 rd_word_en,
    input  logic                                 rd_line_en,
    input  logic [$clog2(NLINES)+$clog2(LINE_WORDS)-1:0] addr,
    input  logic [WORD_W-1:0]                    wdata_word,
    input  logic [LINE_WORDS*WORD_W-1:0]         wdata_line,
    output logic [WORD_W-1:0]                    rd_word,
    output logic [LINE_WORDS*WORD_W-1:0]         rd_line
);
    localparam int OFF_W  = $clog2(LINE_WORDS);
    localparam int IDX_W  = $clog2(NLINES);
    localparam int LINE_W = LINE_WORDS * WORD_W;

    logic [NLINES-1:0][LINE_WORDS-1:0][WORD_W-1:0] mem_d, mem_q;
    logic [IDX_W-1:0] line_idx;
    logic [OFF_W-1:0] word_idx;

    assign line_idx = addr[IDX_W+OFF_W-1:OFF_W];
    assign word_idx = addr[OFF_W-1:0];

    always_comb begin
        mem_d = mem_q;
        if (wr_line_en) begin
            mem_d[line_idx] = wdata_line;
        end else if (wr_word_en) begin
            mem_d[line_idx][word_idx] = wdata_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) mem_q <= '0;
        else     mem_q <= mem_d;
    end

    assign rd_line = rd_line_en ? LINE_W'(mem_q[line_idx]) : '0;
    assign rd_word = rd_word_en ? mem_q[line_idx][word_idx] : '0;

    p_hold_no_write_r2: assert property (@(posedge clk) disable iff (rst)
        !(wr_word_en || wr_line_en) |=> $stable(mem_q));
endmodule

// File: rtl/lockmem.sv
module lockmem #(
    parameter int LAT        = 3,
    parameter int NLINES     = 16,
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 4,
    localparam int AW        = $clog2(NLINES) + $clog2(LINE_WORDS),
    localparam int LINE_W    = LINE_WORDS * WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              d_req,
    input  logic [1:0]        d_op,
    input  logic [AW-1:0]     d_addr,
    input  logic [WORD_W-1:0] d_wword,
    input  logic [LINE_W-1:0] d_wline,
    input  logic              f_req,
    input  logic [1:0]        f_op,
    input  logic [AW-1:0]     f_addr,
    input  logic [WORD_W-1:0] f_wword,
    input  logic [LINE_W-1:0] f_wline,
    output logic              d_done,
    output logic              f_done,
    output logic [WORD_W-1:0] rd_word,
    output logic [LINE_W-1:0] rd_line
);
    import lockmem_pkg::*;

    logic [1:0]  done_vec;
    logic        owner;
    logic        fire;
    mem_op_e     sel_op;
    logic [AW-1:0]     sel_addr;
    logic [WORD_W-1:0] sel_wword;
    logic [LINE_W-1:0] sel_wline;

    lockmem_lock #(.LAT(LAT)) u_lock (
        .clk   (clk),
        .rst   (rst),
        .req   ({f_req, d_req}),
        .done  (done_vec),
        .owner (owner)
    );

    always_comb begin
        sel_op    = mem_op_e'(owner ? f_op : d_op);
        sel_addr  = owner ? f_addr  : d_addr;
        sel_wword = owner ? f_wword : d_wword;
        sel_wline = owner ? f_wline : d_wline;
    end

    assign fire   = |done_vec;
    assign d_done = done_vec[0];
    assign f_done = done_vec[1];

    lockmem_array #(
        .NLINES     (NLINES),
        .WORD_W     (WORD_W),
        .LINE_WORDS (LINE_WORDS)
    ) u_array (
        .clk        (clk),
        .rst        (rst),
        .wr_word_en (fire && sel_op == OP_WR_WORD),
        .wr_line_en (fire && sel_op == OP_WR_LINE),
        .rd_word_en (fire && sel_op == OP_RD_WORD),
        .rd_line_en (fire && sel_op == OP_RD_LINE),
        .addr       (sel_addr),
        .wdata_word (sel_wword),
        .wdata_line (sel_wline),
        .rd_word    (rd_word),
        .rd_line    (rd_line)
    );

    p_idle_reads_zero_r2: assert property (@(posedge clk) disable iff (rst)
        !(d_done || f_done) |-> (rd_word == '0 && rd_line == '0));
    p_single_done_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({d_done, f_done}));
endmodule

// File: tb/lockmem_tb.sv
`timescale 1ns/1ps
module lockmem_tb;
    localparam int LAT = 3;
    localparam int NL  = 16;
    localparam int AW  = 6;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst;
    logic d_req, f_req;
    logic [1:0] d_op, f_op;
    logic [AW-1:0] d_addr, f_addr;
    logic [31:0] d_wword, f_wword;
    logic [127:0] d_wline, f_wline;
    logic d_done, f_done;
    logic [31:0] rd_word;
    logic [127:0] rd_line;

    int checks = 0;
    int fails  = 0;

    lockmem #(.LAT(LAT), .NLINES(NL), .WORD_W(32), .LINE_WORDS(4)) u_dut (
        .clk(clk), .rst(rst),
        .d_req(d_req), .d_op(d_op), .d_addr(d_addr), .d_wword(d_wword), .d_wline(d_wline),
        .f_req(f_req), .f_op(f_op), .f_addr(f_addr), .f_wword(f_wword), .f_wline(f_wline),
        .d_done(d_done), .f_done(f_done), .rd_word(rd_word), .rd_line(rd_line)
    );

    function automatic logic [31:0] lpat(int l, int w);
        return 32'hA000_0000 | (32'(l) << 8) | 32'(w);
    endfunction

    function automatic logic [31:0] wpat(int a);
        return 32'h5500_0000 | 32'(a);
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic drive(input int id, input bit v, input logic [1:0] op, input int addr,
                         input logic [31:0] ww, input logic [127:0] wl);
        if (id == 0) begin
            d_req = v; d_op = op; d_addr = AW'(addr); d_wword = ww; d_wline = wl;
        end else begin
            f_req = v; f_op = op; f_addr = AW'(addr); f_wword = ww; f_wline = wl;
        end
    endtask

    // Called just after a falling edge; returns the read data and the cycle count.
    task automatic access(input int id, input logic [1:0] op, input int addr,
                          input logic [31:0] ww, input logic [127:0] wl,
                          output logic [127:0] rdat, output int cyc);
        logic dn;
        drive(id, 1'b1, op, addr, ww, wl);
        cyc  = 0;
        rdat = '0;
        forever begin
            #1;
            cyc++;
            dn = (id == 0) ? d_done : f_done;
            if (dn) begin
                rdat = (op == 2'b10) ? rd_line : {96'b0, rd_word};
                break;
            end
            if (!d_done && !f_done)
                chk(rd_word == 0 && rd_line == 0, "R2 read outputs zero while waiting",
                    {rd_line ^ {96'b0, rd_word}}, 128'b0);
            if (cyc > 40) begin
                chk(1'b0, "R1 access never completed", 128'(cyc), 128'(LAT + 1));
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
        drive(id, 1'b0, op, addr, ww, wl);
    endtask

    function automatic logic [127:0] fline(int l);
        logic [127:0] v;
        for (int w = 0; w < 4; w++) v[32*w +: 32] = lpat(l, w);
        return v;
    endfunction

    initial begin
        #(200000 * 5);
        chk(1'b0, "watchdog", 128'b0, 128'b1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [127:0] r0, r1, exp;
        int c0, c1;
        rst = 1'b1;
        drive(0, 1'b0, 2'b00, 0, '0, '0);
        drive(1, 1'b0, 2'b00, 0, '0, '0);
        repeat (3) @(negedge clk);
        #1;
        chk(!d_done && !f_done, "R10 done flags low in reset", {126'b0, f_done, d_done}, 128'b0);
        @(negedge clk);
        rst = 1'b0;

        // R10: storage empty after reset
        access(0, 2'b10, 0, '0, '0, r0, c0);
        chk(r0 == 0, "R10 line 0 zero after reset", r0, 128'b0);
        access(1, 2'b10, (NL - 1) * 4, '0, '0, r1, c1);
        chk(r1 == 0, "R10 last line zero after reset", r1, 128'b0);

        // R7, R1: write every line, low bits varied and ignored
        for (int l = 0; l < NL; l++) begin
            access(0, 2'b11, l * 4 + (l % 4), '0, fline(l), r0, c0);
            chk(c0 == LAT + 1, "R1 line write latency", 128'(c0), 128'(LAT + 1));
        end

        // R6, R8: back-to-back word reads over every address, each full latency
        for (int a = 0; a < NL * 4; a++) begin
            access(1, 2'b00, a, '0, '0, r1, c1);
            chk(r1 == {96'b0, lpat(a / 4, a % 4)}, "R6 word read selects word",
                r1, {96'b0, lpat(a / 4, a % 4)});
            chk(c1 == LAT + 1, "R8 consecutive word read latency", 128'(c1), 128'(LAT + 1));
        end

        // R6: word writes to odd words, then line reads with low bits set (R7)
        for (int a = 1; a < NL * 4; a += 2)
            access(1, 2'b01, a, wpat(a), '0, r1, c1);
        for (int l = 0; l < NL; l++) begin
            exp = fline(l);
            for (int w = 1; w < 4; w += 2) exp[32*w +: 32] = wpat(l * 4 + w);
            access(0, 2'b10, l * 4 + 2, '0, '0, r0, c0);
            chk(r0 == exp, "R7 line read merges word writes", r0, exp);
        end

        // R5, R3: simultaneous start, data wins, fetch sees new value
        fork
            access(0, 2'b11, 8, '0, ~fline(2), r0, c0);
            access(1, 2'b10, 8, '0, '0, r1, c1);
        join
        chk(c0 == LAT + 1, "R5 data side first", 128'(c0), 128'(LAT + 1));
        chk(c1 == 2 * (LAT + 1), "R3 fetch stalled behind owner", 128'(c1), 128'(2 * (LAT + 1)));
        chk(r1 == ~fline(2), "R5 fetch reads owner's write", r1, ~fline(2));

        // R4: fetch arrives one cycle after data
        fork
            access(0, 2'b10, 12, '0, '0, r0, c0);
            begin
                @(negedge clk);
                access(1, 2'b10, 16, '0, '0, r1, c1);
            end
        join
        chk(c0 == LAT + 1, "R4 owner latency", 128'(c0), 128'(LAT + 1));
        chk(c1 == 2 * LAT + 1, "R4 waiter latency", 128'(c1), 128'(2 * LAT + 1));

        // R9: data write word aborted after two cycles, fetch waiting reads old value
        fork
            access(1, 2'b00, 5, '0, '0, r1, c1);
            begin
                drive(0, 1'b1, 2'b01, 5, 32'hDEAD_BEEF, '0);
                #1;
                chk(!d_done, "R9 no done before abort", {127'b0, d_done}, 128'b0);
                @(negedge clk);
                #1;
                chk(!d_done, "R9 no done before abort", {127'b0, d_done}, 128'b0);
                @(negedge clk);
                drive(0, 1'b0, 2'b01, 5, 32'hDEAD_BEEF, '0);
            end
        join
        chk(c1 == 3 + LAT + 1, "R9 lock freed after abort", 128'(c1), 128'(3 + LAT + 1));
        chk(r1 == {96'b0, wpat(5)}, "R9 aborted write has no effect", r1, {96'b0, wpat(5)});
        access(0, 2'b00, 5, '0, '0, r0, c0);
        chk(r0 == {96'b0, wpat(5)}, "R2 storage unchanged by abort", r0, {96'b0, wpat(5)});

        // R10: reset mid-run clears contents
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        access(1, 2'b10, 4, '0, '0, r1, c1);
        chk(r1 == 0, "R10 line cleared by reset", r1, 128'b0);
        chk(c1 == LAT + 1, "R10 lock idle after reset", 128'(c1), 128'(LAT + 1));

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule